// File: doc/BRIEF.md
# Shared Event Queue with Interrupt Flag

This block collects one-byte events from three producers, a key-matrix scanner, a bank of general-purpose inputs and the logic blocks, and keeps them in a single 16-deep first-in first-out queue. A processor drains the queue through one read strobe, so a single read path serves every producer. Each byte holds a press/release (active/inactive) state bit in bit 7 and a 7-bit event identifier in bits 6:0. Identifier 0 is reserved to mean "no event".

A live entry counter is always visible. An interrupt flag rises whenever an event is actually stored and stays up until software clears it. A sticky overflow flag records that an event was lost to a full queue. A freeze input, driven by the keypad lock controller, suspends all queue traffic and counter updates while the keypad is locked.

Top module: `evtq_top`

## Requirements
- R1: `evt_count` reports the number of held entries (0 to 16), updates on the clock edge that stores or removes an entry, and never exceeds 16.
- R2: Bytes are returned unchanged and in arrival order: bit 7 is the state bit, bits 6:0 the identifier.
- R3: An event offered while 16 entries are held and no pop is accepted in that cycle is dropped and sets `ovf_flag`; the flag stays set until a cycle with `ovf_clr` high and no new overflow, and a new overflow wins over a clear in the same cycle.
- R4: A pop strobe on an empty queue makes `rd_data` 0x00 on the next cycle and leaves `evt_count` unchanged.
- R5: A pop strobe on a non-empty queue places the oldest byte on `rd_data` on the next cycle and lowers `evt_count` by one; `rd_data` holds its value in cycles without a pop strobe.
- R6: An accepted store and an accepted pop in one cycle leave `evt_count` unchanged; at 16 entries this stores the new event and does not set `ovf_flag`.
- R7: When several producers offer in the same cycle, only one byte is stored, chosen with priority keypad over general-purpose input over logic block; the others are discarded without setting `ovf_flag`.
- R8: An offered byte whose bits 6:0 are zero is ignored: nothing is stored and no flag changes, and it does not block a lower-priority producer.
- R9: While `freeze` is high no byte is stored, none is removed, `evt_count` holds, no flag is set, and a pop strobe returns 0x00.
- R10: `evt_int` is set on every cycle that stores an event and stays set until a cycle with `int_clr` high and no store; a store wins over a clear in the same cycle.
- R11: After reset the queue is empty, `evt_count` is 0, both flags are low and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_vld | input | 1 | Keypad producer offers a byte |
| key_evt | input | 8 | Keypad event byte |
| gpi_vld | input | 1 | General-purpose input producer offers a byte |
| gpi_evt | input | 8 | General-purpose input event byte |
| lgc_vld | input | 1 | Logic-block producer offers a byte |
| lgc_evt | input | 8 | Logic-block event byte |
| freeze | input | 1 | Lock active: suspend queue and counter |
| rd_pop | input | 1 | Read strobe for the head entry |
| int_clr | input | 1 | Clear the event interrupt flag |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_data | output | 8 | Byte returned by the last read strobe |
| evt_count | output | 5 | Number of held entries |
| evt_int | output | 1 | Event interrupt flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench drives the queue to 16 entries and keeps offering events, which catches a design that wraps its write pointer over unread data or that forgets to flag the loss. It combines a pop with a store on a full queue, where a wrong design either drops the new byte, raises a false overflow or lets the count drift. Reads on an empty or frozen queue are hit to expose a design that returns stale memory or decrements the count below zero, and clears are issued in the same cycle as new events to expose a clear that wrongly wins. Same-cycle offers from all producers, some with identifier 0, check the arbitration order and that a null byte does not steal the slot.

// File: rtl/evtq_pkg.sv
package evtq_pkg;

    localparam int EVT_W  = 8;
    localparam int ID_W   = EVT_W - 1;
    localparam int N_SRC  = 3;

    typedef struct packed {
        logic            active;
        logic [ID_W-1:0] id;
    } evt_t;

    // order is the arbitration priority, index 0 highest
    typedef enum logic [1:0] {
        SRC_KEY = 2'd0,
        SRC_GPI = 2'd1,
        SRC_LGC = 2'd2
    } src_e;

    function automatic logic is_event(evt_t e);
        return e.id != '0;
    endfunction

endpackage

// File: rtl/evtq_arb.sv
module evtq_arb
    import evtq_pkg::*;
(
    input  logic [N_SRC-1:0] src_vld,
    input  evt_t             src_evt [N_SRC],
    output logic             req,
    output evt_t             evt
);

    always_comb begin
        req = 1'b0;
        evt = '0;
        // walk from lowest to highest priority so the highest overwrites
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (src_vld[i] && is_event(src_evt[i])) begin
                req = 1'b1;
                evt = src_evt[i];
            end
        end
    end

endmodule

// File: rtl/evtq_store.sv
module evtq_store
    import evtq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         rd_strobe,
    input  evt_t                         din,
    output evt_t                         rd_q,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         stored,
    output logic                         lost
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    evt_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, empty, pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] step_ptr(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign stored  = push_ok;
    assign lost    = push && full && !pop_ok;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rd_q   <= '0;
        end else begin
            if (push_ok) wr_ptr <= step_ptr(wr_ptr);
            if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (rd_strobe) rd_q <= pop_ok ? mem[rd_ptr] : '0;
        end
    end

endmodule

// File: rtl/evtq_flags.sv
module evtq_flags (
    input  logic clk,
    input  logic rst,
    input  logic stored,
    input  logic lost,
    input  logic int_clr,
    input  logic ovf_clr,
    output logic int_q,
    output logic ovf_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (stored)       int_q <= 1'b1;
            else if (int_clr) int_q <= 1'b0;
            if (lost)         ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;
        end
    end

endmodule

// File: rtl/evtq_top.sv
module evtq_top
    import evtq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       key_vld,
    input  logic [7:0]                 key_evt,
    input  logic                       gpi_vld,
    input  logic [7:0]                 gpi_evt,
    input  logic                       lgc_vld,
    input  logic [7:0]                 lgc_evt,
    input  logic                       freeze,
    input  logic                       rd_pop,
    input  logic                       int_clr,
    input  logic                       ovf_clr,
    output logic [7:0]                 rd_data,
    output logic [$clog2(DEPTH+1)-1:0] evt_count,
    output logic                       evt_int,
    output logic                       ovf_flag
);

    logic [N_SRC-1:0] src_vld;
    evt_t             src_evt [N_SRC];
    logic             arb_req, stored, lost;
    evt_t             arb_evt, rd_q;

    assign src_vld[SRC_KEY] = key_vld;
    assign src_vld[SRC_GPI] = gpi_vld;
    assign src_vld[SRC_LGC] = lgc_vld;
    assign src_evt[SRC_KEY] = evt_t'(key_evt);
    assign src_evt[SRC_GPI] = evt_t'(gpi_evt);
    assign src_evt[SRC_LGC] = evt_t'(lgc_evt);

    evtq_arb u_arb (
        .src_vld (src_vld),
        .src_evt (src_evt),
        .req     (arb_req),
        .evt     (arb_evt)
    );

    evtq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (arb_req && !freeze),
        .pop       (rd_pop && !freeze),
        .rd_strobe (rd_pop),
        .din       (arb_evt),
        .rd_q      (rd_q),
        .count     (evt_count),
        .stored    (stored),
        .lost      (lost)
    );

    evtq_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .stored  (stored),
        .lost    (lost),
        .int_clr (int_clr),
        .ovf_clr (ovf_clr),
        .int_q   (evt_int),
        .ovf_q   (ovf_flag)
    );

    assign rd_data = rd_q;

endmodule

// File: rtl/evtq_chk.sv
module evtq_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       key_vld,
    input logic [7:0]                 key_evt,
    input logic                       gpi_vld,
    input logic [7:0]                 gpi_evt,
    input logic                       lgc_vld,
    input logic [7:0]                 lgc_evt,
    input logic                       freeze,
    input logic                       rd_pop,
    input logic                       int_clr,
    input logic                       ovf_clr,
    input logic [7:0]                 rd_data,
    input logic [$clog2(DEPTH+1)-1:0] evt_count,
    input logic                       evt_int,
    input logic                       ovf_flag
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic any_evt, ovf_cond;
    assign any_evt  = (key_vld && key_evt[6:0] != 7'd0) ||
                      (gpi_vld && gpi_evt[6:0] != 7'd0) ||
                      (lgc_vld && lgc_evt[6:0] != 7'd0);
    assign ovf_cond = any_evt && !freeze && !rd_pop && evt_count == CNT_W'(DEPTH);

    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        evt_count <= CNT_W'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_cond |=> ovf_flag);

    p_ovf_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !ovf_cond) |=> !ovf_flag);

    p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && evt_count == '0) |=> rd_data == 8'h00);

    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (rst)
        freeze |=> evt_count == $past(evt_count));

    p_int_on_store_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_count > $past(evt_count)) |-> evt_int);

    p_int_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_int && !int_clr) |=> evt_int);

endmodule

bind evtq_top evtq_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/evtq_top_tb_top.sv
`timescale 1ns/1ps
module evtq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_vld = 0, gpi_vld = 0, lgc_vld = 0;
    logic [7:0] key_evt = 0, gpi_evt = 0, lgc_evt = 0;
    logic       freeze = 0, rd_pop = 0, int_clr = 0, ovf_clr = 0;
    logic [7:0] rd_data;
    logic [4:0] evt_count;
    logic       evt_int, ovf_flag;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mq[$];
    logic [7:0] m_rd = 0;
    logic       m_int = 0, m_ovf = 0;

    always #4 clk = ~clk;

    evtq_top dut_i (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic valid_evt(logic v, logic [7:0] e);
        return v && e[6:0] != 7'd0;
    endfunction

    // drive at a falling edge, update the model, compare at the next falling edge
    task automatic step(string tag, logic kv, logic [7:0] ke, logic gv, logic [7:0] ge,
                        logic lv, logic [7:0] le, logic frz, logic pop,
                        logic ic, logic oc);
        logic       has, pop_ok, push_ok;
        logic [7:0] sel;
        key_vld = kv; key_evt = ke; gpi_vld = gv; gpi_evt = ge;
        lgc_vld = lv; lgc_evt = le; freeze = frz; rd_pop = pop;
        int_clr = ic; ovf_clr = oc;
        has = 1'b1;
        if (valid_evt(kv, ke))      sel = ke;
        else if (valid_evt(gv, ge)) sel = ge;
        else if (valid_evt(lv, le)) sel = le;
        else begin has = 1'b0; sel = 0; end
        pop_ok  = !frz && pop && mq.size() > 0;
        push_ok = !frz && has && (mq.size() < 16 || pop_ok);
        if (pop) m_rd = pop_ok ? mq[0] : 8'h00;
        if (!frz && has && mq.size() == 16 && !pop_ok) m_ovf = 1'b1;
        else if (oc) m_ovf = 1'b0;
        if (push_ok) m_int = 1'b1;
        else if (ic) m_int = 1'b0;
        if (pop_ok)  void'(mq.pop_front());
        if (push_ok) mq.push_back(sel);
        @(negedge clk);
        chk({tag, " rd_data"}, rd_data, m_rd);
        chk({tag, " count"}, evt_count, mq.size());
        chk({tag, " int"}, evt_int, m_int);
        chk({tag, " ovf"}, ovf_flag, m_ovf);
    endtask

    task automatic push1(string tag, logic [7:0] e);
        step(tag, 1, e, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic pop1(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 count", evt_count, 0);
        chk("R11 int", evt_int, 0);
        chk("R11 ovf", ovf_flag, 0);
        chk("R11 rd_data", rd_data, 0);
        // R4 empty read
        pop1("R4");
        // R2 / R10 / R5 storage, order, format
        push1("R10", 8'h85);
        step("R2", 0, 0, 1, 8'h03, 0, 0, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0, 0);
        pop1("R5"); pop1("R5"); pop1("R2"); pop1("R4");
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R10 store wins over clear
        step("R10", 1, 8'h11, 0, 0, 0, 0, 0, 0, 1, 0);
        pop1("R5");
        // R7 priority
        step("R7", 1, 8'h21, 1, 8'h22, 1, 8'h23, 0, 0, 0, 0);
        step("R7", 0, 0, 1, 8'hA2, 1, 8'h23, 0, 0, 0, 0);
        pop1("R7"); pop1("R7");
        // R8 null identifiers
        step("R8", 1, 8'h80, 1, 8'h00, 1, 8'h80, 0, 0, 0, 0);
        step("R8", 1, 8'h80, 0, 0, 1, 8'h45, 0, 0, 0, 0);
        pop1("R8");
        // R9 freeze
        push1("R9", 8'h31);
        step("R9", 1, 8'h32, 0, 0, 0, 0, 1, 1, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        // fill, overflow, push+pop at full
        for (int i = 1; i <= 16; i++) push1("R1", 8'(i));
        push1("R3", 8'h77);
        step("R6", 1, 8'h55, 0, 0, 0, 0, 0, 1, 0, 1);
        step("R3", 1, 8'h56, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 17; i++) pop1("R2");
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a, b, c;
            a = 8'($urandom); b = 8'($urandom); c = 8'($urandom);
            if ($urandom_range(0, 7) == 0) a[6:0] = 0;
            step("RND", $urandom_range(0, 9) < 4, a, $urandom_range(0, 9) < 3, b,
                 $urandom_range(0, 9) < 3, c, $urandom_range(0, 9) == 0,
                 $urandom_range(0, 9) < 4, $urandom_range(0, 9) == 0,
                 $urandom_range(0, 9) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule